// File: doc/BRIEF.md
# Trace Record Ring Buffer

The block records one 256-bit trace record on every clock into a circular on-chip RAM and lets two independent agents read the history back. One agent is the processor and the other is the debug port. Each agent owns a pair of 64-bit registers: a position register and a data register. Reading the position register shows where capture is currently writing. Writing it moves that agent's readout cursor and sets that agent's hold flag. Each request on the data register returns one 64-bit doubleword and advances the cursor by one.

The record stream has no handshake because the traced logic cannot be stalled. While capture runs, the input is taken on every clock. Capture is held off only when a hold flag is set in at least one of the two position registers. Holding capture keeps the stored history stable so it can be read out.

A data read is a single-cycle request pulse. The doubleword is returned one clock later, together with a one-cycle valid strobe. The readout side has no back-pressure because the register pair is always ready. The depth is a parameter. A depth of zero removes the storage and all capture logic.

Top module: `trace_ring`

## Requirements
- R1: While capture is not held, each clock edge stores `trace_in` into the entry selected by the capture pointer, and the capture pointer then advances by one, wrapping from DEPTH-1 to 0.
- R2: Bits 63:32 of a position register read as the capture pointer (counted in entries) ORed with DEPTH. DEPTH is a power of two, so software can recover it as the highest set bit of that field.
- R3: Bit 31 of a position register reads as that agent's hold flag. Bits [RW-1:0] read as its cursor in doublewords, with RW = log2(DEPTH)+2. Cursor value 4*e+d selects bits [64d+63:64d] of entry e. The remaining bits read as zero.
- R4: A data read pulse makes `*_data_rvalid` high on the next cycle, with the doubleword at the cursor on `*_data_rdata`. The cursor then advances by one modulo 4*DEPTH.
- R5: While the hold flag of either agent is 1, no entry is written and the capture pointer stays put.
- R6: Writing a position register loads the cursor from bits [RW-1:0] and the hold flag from bit 31. Bits 63:32 of the written value are ignored, and the capture pointer cannot be changed.
- R7: A position write and a data read on the same agent in the same cycle return the doubleword at the old cursor, and the cursor takes the written value.
- R8: A read of the entry that is being captured in the same cycle returns that entry's previous contents.
- R9: The two agents have separate cursors and hold flags, and both may read in the same cycle.
- R10: With DEPTH = 0, the data reads return zero and bits 63:32 of the position register read as zero.
- R11: After reset, the capture pointer, both cursors, both hold flags and both valid strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_in | input | ENTRY_W | Trace record captured each unheld cycle |
| cpu_addr_we | input | 1 | Processor position register write strobe |
| cpu_addr_wdata | input | 64 | Processor position register write value |
| cpu_addr_rdata | output | 64 | Processor position register read value |
| cpu_data_re | input | 1 | Processor data read request |
| cpu_data_rvalid | output | 1 | Processor read data valid |
| cpu_data_rdata | output | 64 | Processor read doubleword |
| dbg_addr_we | input | 1 | Debug position register write strobe |
| dbg_addr_wdata | input | 64 | Debug position register write value |
| dbg_addr_rdata | output | 64 | Debug position register read value |
| dbg_data_re | input | 1 | Debug data read request |
| dbg_data_rvalid | output | 1 | Debug read data valid |
| dbg_data_rdata | output | 64 | Debug read doubleword |

## Verification
Capture and readout can land on the same entry in one clock. The bench provokes this by loading the processor cursor with the entry that will be written two edges later, then issuing the read on that edge. The bench model performs its read before its write within each edge, so the expected value is the old contents and the new record must not appear. A position write combined with a read in one cycle is also driven on purpose and judged against the old cursor.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;
  localparam int DWORD_W    = 64;
  localparam int HOLD_BIT   = 31;
  localparam int CAP_LSB    = 32;

  function automatic int idx_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/trace_ring_wrptr.sv
module trace_ring_wrptr #(
  parameter int DEPTH = 2048,
  localparam int IDX_W = trace_ring_pkg::idx_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_any,
  output logic [IDX_W-1:0] cap_ptr,
  output logic             cap_we
);
  if (DEPTH > 0) begin : g_on
    logic [IDX_W-1:0] ptr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ptr_q <= '0;
      else if (!hold_any) ptr_q <= ptr_q + 1'b1;
    end
    assign cap_ptr = ptr_q;
    assign cap_we  = !hold_any;

    assert_hold_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hold_any |=> $stable(ptr_q));
    assert_ptr_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_any && ptr_q == IDX_W'(DEPTH-1)) |=> ptr_q == '0);
  end else begin : g_off
    assign cap_ptr = '0;
    assign cap_we  = 1'b0;
  end
endmodule

// File: rtl/trace_ring_store.sv
module trace_ring_store #(
  parameter int DEPTH   = 2048,
  parameter int ENTRY_W = 256,
  parameter int NPORT   = 2,
  localparam int IDX_W  = trace_ring_pkg::idx_bits(DEPTH),
  localparam int SEL_W  = $clog2(ENTRY_W / trace_ring_pkg::DWORD_W),
  localparam int RPTR_W = IDX_W + SEL_W
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [ENTRY_W-1:0]            wr_data,
  input  logic [NPORT-1:0]              rd_en,
  input  logic [NPORT-1:0][RPTR_W-1:0]  rd_ptr,
  output logic [NPORT-1:0][63:0]        rd_data
);
  if (DEPTH > 0) begin : g_ram
    logic [ENTRY_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
    end
    for (genvar p = 0; p < NPORT; p++) begin : g_rd
      logic [63:0] q;
      always_ff @(posedge clk) begin
        if (rd_en[p])
          q <= mem[rd_ptr[p][RPTR_W-1:SEL_W]][64*int'(rd_ptr[p][SEL_W-1:0]) +: 64];
      end
      assign rd_data[p] = q;
    end
  end else begin : g_none
    assign rd_data = '0;
  end
endmodule

// File: rtl/trace_ring_regport.sv
module trace_ring_regport #(
  parameter int RPTR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic [63:0]       addr_wdata,
  input  logic              data_re,
  input  logic [31:0]       cap_field,
  output logic [63:0]       addr_rdata,
  output logic [RPTR_W-1:0] cursor,
  output logic              hold,
  output logic              rvalid
);
  import trace_ring_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cursor <= '0;
      hold   <= 1'b0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= data_re;
      if (addr_we) begin
        cursor <= addr_wdata[RPTR_W-1:0];
        hold   <= addr_wdata[HOLD_BIT];
      end else if (data_re) begin
        cursor <= cursor + 1'b1;
      end
    end
  end

  assign addr_rdata = {cap_field, hold, (HOLD_BIT-RPTR_W)'(0), cursor};

  assert_cursor_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_re && !addr_we) |=> (cursor - $past(cursor)) == RPTR_W'(1));
  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> (cursor == $past(addr_wdata[RPTR_W-1:0]) && hold == $past(addr_wdata[HOLD_BIT])));
endmodule

// File: rtl/trace_ring.sv
module trace_ring #(
  parameter int DEPTH   = 2048,
  parameter int ENTRY_W = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRY_W-1:0] trace_in,
  input  logic               cpu_addr_we,
  input  logic [63:0]        cpu_addr_wdata,
  output logic [63:0]        cpu_addr_rdata,
  input  logic               cpu_data_re,
  output logic               cpu_data_rvalid,
  output logic [63:0]        cpu_data_rdata,
  input  logic               dbg_addr_we,
  input  logic [63:0]        dbg_addr_wdata,
  output logic [63:0]        dbg_addr_rdata,
  input  logic               dbg_data_re,
  output logic               dbg_data_rvalid,
  output logic [63:0]        dbg_data_rdata
);
  import trace_ring_pkg::*;
  localparam int NPORT  = 2;
  localparam int IDX_W  = idx_bits(DEPTH);
  localparam int SEL_W  = $clog2(ENTRY_W / DWORD_W);
  localparam int RPTR_W = IDX_W + SEL_W;

  logic [NPORT-1:0]             p_we, p_re, p_rv, p_hold;
  logic [NPORT-1:0][63:0]       p_wd, p_ad, p_rd;
  logic [NPORT-1:0][RPTR_W-1:0] p_cur;
  logic [IDX_W-1:0]             cap_ptr;
  logic                         cap_we, hold_any;
  logic [31:0]                  cap_field;

  assign p_we = {dbg_addr_we, cpu_addr_we};
  assign p_re = {dbg_data_re, cpu_data_re};
  assign p_wd = {dbg_addr_wdata, cpu_addr_wdata};

  assign hold_any  = |p_hold;
  assign cap_field = 32'(DEPTH) | 32'(cap_ptr);

  trace_ring_wrptr #(.DEPTH(DEPTH)) u_wrptr (
    .clk(clk), .rst_n(rst_n), .hold_any(hold_any),
    .cap_ptr(cap_ptr), .cap_we(cap_we));

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    trace_ring_regport #(.RPTR_W(RPTR_W)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .addr_we(p_we[p]), .addr_wdata(p_wd[p]), .data_re(p_re[p]),
      .cap_field(cap_field), .addr_rdata(p_ad[p]),
      .cursor(p_cur[p]), .hold(p_hold[p]), .rvalid(p_rv[p]));
  end

  trace_ring_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .NPORT(NPORT)) u_store (
    .clk(clk), .wr_en(cap_we), .wr_idx(cap_ptr), .wr_data(trace_in),
    .rd_en(p_re), .rd_ptr(p_cur), .rd_data(p_rd));

  assign cpu_addr_rdata  = p_ad[0];
  assign dbg_addr_rdata  = p_ad[1];
  assign cpu_data_rvalid = p_rv[0];
  assign dbg_data_rvalid = p_rv[1];
  assign cpu_data_rdata  = p_rd[0];
  assign dbg_data_rdata  = p_rd[1];

  assert_hold_from_either_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (p_hold[0] || p_hold[1]) |=> $stable(cap_field));
endmodule

// File: tb/trace_ring_tb_top.sv
`timescale 1ns/1ps
module trace_ring_tb_top;
  localparam int DEPTH = 2048;
  localparam int RW    = $clog2(DEPTH) + 2;
  localparam int RMOD  = DEPTH * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [255:0] trace_in = '0;
  logic         we_b [2];
  logic         re_b [2];
  logic [63:0]  wd_b [2];
  logic [63:0]  ad_o [2];
  logic         rv_o [2];
  logic [63:0]  rd_o [2];
  logic [63:0]  z_ad [2];
  logic         z_rv [2];
  logic [63:0]  z_rd [2];

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  trace_ring #(.DEPTH(DEPTH), .ENTRY_W(256)) dut_i (
    .clk(clk), .rst_n(rst_n), .trace_in(trace_in),
    .cpu_addr_we(we_b[0]), .cpu_addr_wdata(wd_b[0]), .cpu_addr_rdata(ad_o[0]),
    .cpu_data_re(re_b[0]), .cpu_data_rvalid(rv_o[0]), .cpu_data_rdata(rd_o[0]),
    .dbg_addr_we(we_b[1]), .dbg_addr_wdata(wd_b[1]), .dbg_addr_rdata(ad_o[1]),
    .dbg_data_re(re_b[1]), .dbg_data_rvalid(rv_o[1]), .dbg_data_rdata(rd_o[1]));

  trace_ring #(.DEPTH(0), .ENTRY_W(256)) dut_z (
    .clk(clk), .rst_n(rst_n), .trace_in(trace_in),
    .cpu_addr_we(we_b[0]), .cpu_addr_wdata(wd_b[0]), .cpu_addr_rdata(z_ad[0]),
    .cpu_data_re(re_b[0]), .cpu_data_rvalid(z_rv[0]), .cpu_data_rdata(z_rd[0]),
    .dbg_addr_we(we_b[1]), .dbg_addr_wdata(wd_b[1]), .dbg_addr_rdata(z_ad[1]),
    .dbg_data_re(re_b[1]), .dbg_data_rvalid(z_rv[1]), .dbg_data_rdata(z_rd[1]));

  // Reference model: reads see memory before this edge's capture write.
  logic [255:0] mem_m [DEPTH];
  int unsigned  wptr_m;
  int unsigned  cur_m [2];
  bit           hold_m [2];
  bit           ev [2];
  logic [63:0]  erd [2];
  bit           frz;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_m = 0;
      for (int p = 0; p < 2; p++) begin cur_m[p] = 0; hold_m[p] = 0; ev[p] = 0; end
    end else begin
      frz = hold_m[0] | hold_m[1];
      for (int p = 0; p < 2; p++) begin
        ev[p] = re_b[p];
        if (re_b[p]) erd[p] = mem_m[cur_m[p] / 4][(cur_m[p] % 4) * 64 +: 64];
      end
      if (!frz) begin
        mem_m[wptr_m] = trace_in;
        wptr_m = (wptr_m + 1) % DEPTH;
      end
      for (int p = 0; p < 2; p++) begin
        if (we_b[p]) begin
          cur_m[p]  = wd_b[p] % RMOD;
          hold_m[p] = wd_b[p][31];
        end else if (re_b[p]) begin
          cur_m[p] = (cur_m[p] + 1) % RMOD;
        end
      end
    end
  end

  function automatic logic [63:0] exp_addr(input int p);
    return {32'(DEPTH) | 32'(wptr_m), hold_m[p], (31-RW)'(0), RW'(cur_m[p])};
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int p = 0; p < 2; p++) begin
      chk(tag, "position", ad_o[p], exp_addr(p));
      chk(tag, "rvalid", {63'b0, rv_o[p]}, {63'b0, ev[p]});
      if (ev[p]) chk(tag, "rdata", rd_o[p], erd[p]);
      chk("R10", "zero-depth upper", {32'b0, z_ad[p][63:32]}, 64'b0);
      if (z_rv[p]) chk("R10", "zero-depth rdata", z_rd[p], 64'b0);
    end
  endtask

  task automatic rand_trace();
    for (int i = 0; i < 8; i++) trace_in[i*32 +: 32] = $urandom;
  endtask

  task automatic cycle(input string tag);
    @(negedge clk);
    check_all(tag);
    for (int p = 0; p < 2; p++) begin we_b[p] = 0; re_b[p] = 0; end
    rand_trace();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < 2; p++) begin we_b[p] = 0; re_b[p] = 0; wd_b[p] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    check_all("R11");
    chk("R11", "cpu position", ad_o[0], {32'(DEPTH), 32'b0});
    chk("R11", "dbg position", ad_o[1], {32'(DEPTH), 32'b0});

    // R1, R2: fill the whole ring and wrap once
    for (int i = 0; i < DEPTH + 40; i++) cycle("R1,R2");

    // R5, R6: debug side alone holds capture
    we_b[1] = 1; wd_b[1] = 64'hFFFF_FFFF_8000_0000 | 64'(17); cycle("R6");
    for (int i = 0; i < 12; i++) begin re_b[0] = 1; cycle("R5"); end
    we_b[1] = 1; wd_b[1] = 64'(3); cycle("R6");

    // R8: read the entry being captured on the same edge
    we_b[0] = 1; wd_b[0] = 64'(((wptr_m + 1) % DEPTH) * 4 + 2); cycle("R6");
    re_b[0] = 1; cycle("R8");
    cycle("R8");

    // R7: position write together with data read
    we_b[0] = 1; re_b[0] = 1; wd_b[0] = 64'(RMOD - 1 + 5 * 4); cycle("R7");
    re_b[0] = 1; cycle("R7");

    // R9: both agents read in the same cycle from different cursors
    re_b[0] = 1; re_b[1] = 1; cycle("R9");
    re_b[0] = 1; re_b[1] = 1; cycle("R9");

    // Random mixed traffic, cursor wrap near RMOD included
    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < 2; p++) begin
        re_b[p] = ($urandom % 2) == 0;
        if (($urandom % 20) == 0) begin
          we_b[p] = 1;
          wd_b[p] = {$urandom, $urandom};
          wd_b[p][31] = (($urandom % 6) == 0);
        end
      end
      cycle("R1,R2,R3,R4,R5,R6,R9");
    end
    // release any hold left by random traffic
    we_b[0] = 1; wd_b[0] = 64'(RMOD - 2); we_b[1] = 1; wd_b[1] = 64'(0); cycle("R6");
    for (int i = 0; i < 4; i++) begin re_b[0] = 1; cycle("R3,R4"); end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule